// File: doc/BRIEF.md
# Completion-Detecting Dual-Rail Carry Adder

This block is an N-bit adder whose latency follows its operands instead of a fixed worst case. It works like a self-timed ripple adder inside a clocked design. Each carry is held as a pair of rails that starts empty. A position whose two operand bits are equal settles its carry-out in the first step. A position whose operand bits differ passes on the value of its lower neighbour, one position per clock. A completion flag rises once every pair has settled, and from then on the sum is valid.

A client pulses a request carrying two operands and a carry-in while the adder is idle. It then waits for the completion flag, and reads the sum, the carry-out and the number of steps the addition took. All carry pairs return to empty when a request is accepted, and the flag drops until the new result settles.

Top module: `rda_adder`

## Requirements
- R1: Every carry pair uses the code 2'b00 for empty, 2'b01 for false and 2'b10 for true (bit 1 is the true rail). The code 2'b11 never appears.
- R2: Within one addition a carry pair changes at most once: from empty to a valid code. After that it holds until the next accepted request.
- R3: In the first step after acceptance, the carry into bit 0 settles from the carry-in. In the same step every position with two equal operand bits settles its carry-out: true for 1,1 and false for 0,0. Adding 0 to 0 therefore completes in exactly 1 step.
- R4: A position with unequal operand bits settles its carry-out one step after its incoming carry has settled, and copies that incoming value.
- R5: `resp_done` is high exactly when every carry pair has settled after an accepted request. It stays high until the next request is accepted.
- R6: While `resp_done` is high, {`resp_cout`,`resp_sum`} equals A + B + carry-in.
- R7: `resp_cycles` reports the number of steps, which is 1 plus the longest run of consecutive positions with unequal operand bits. 0 + 1 takes 2 steps. All-ones + 1 takes N steps. All-ones + 0 with carry-in 1 takes N+1 steps.
- R8: A request is accepted when `req_valid` is high and no addition is in progress. In the cycle after acceptance, `resp_done` is low and `resp_cycles` is 0.
- R9: A request raised while an addition is in progress is ignored. The result still reflects the earlier operands.
- R10: After reset, `resp_done` is low and `resp_cycles` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_a | input | W | First operand |
| req_b | input | W | Second operand |
| req_cin | input | 1 | Carry-in |
| resp_done | output | 1 | All carries settled; result valid |
| resp_sum | output | W | Sum |
| resp_cout | output | 1 | Carry-out |
| resp_cycles | output | CW | Steps taken by the addition |

## Verification
Assertions check four rules on every cycle: no pair ever holds the illegal code, a settled pair never moves again, a propagating position copies its neighbour in the very next step, and the completion flag holds until acceptance and drops right after it. The bench's scenarios are what show that the arithmetic result is correct and that the step count matches the longest propagate run. They cover the extreme operand patterns and random vectors. They also show that a request raised during a busy addition leaves the result untouched.

// File: rtl/rda_pkg.sv
package rda_pkg;
  typedef logic [1:0] rail_t;
  localparam rail_t RAIL_EMPTY = 2'b00;
  localparam rail_t RAIL_FALSE = 2'b01;
  localparam rail_t RAIL_TRUE  = 2'b10;

  function automatic logic rail_known(input rail_t r);
    return r == RAIL_FALSE || r == RAIL_TRUE;
  endfunction

  function automatic rail_t rail_from_bit(input logic v);
    return v ? RAIL_TRUE : RAIL_FALSE;
  endfunction

  function automatic logic rail_value(input rail_t r);
    return r[1];
  endfunction
endpackage

// File: rtl/rda_cell.sv
module rda_cell
  import rda_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  step,
  input  logic  a,
  input  logic  b,
  input  rail_t cin_pair,
  output rail_t cout_pair
);
  rail_t pair_q;
  logic  is_prop;
  logic  settle_now;

  assign is_prop    = a ^ b;
  assign settle_now = step && !rail_known(pair_q) && (!is_prop || rail_known(cin_pair));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pair_q <= RAIL_EMPTY;
    else if (clear)      pair_q <= RAIL_EMPTY;
    else if (settle_now) pair_q <= is_prop ? cin_pair : rail_from_bit(a);
  end

  assign cout_pair = pair_q;

  // R1
  pair_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_q != 2'b11);
  // R2
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rail_known(pair_q) && !clear |=> $stable(pair_q));
  // R4
  prop_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clear && is_prop && !rail_known(pair_q) && rail_known(cin_pair)
      |=> pair_q == $past(cin_pair));
endmodule

// File: rtl/rda_ctrl.sv
module rda_ctrl #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          all_known,
  output logic          accept,
  output logic          step,
  output logic          done,
  output logic [CW-1:0] cycles
);
  logic started_q;
  logic busy;

  assign busy   = started_q && !all_known;
  assign accept = req_valid && !busy;
  assign step   = busy;
  assign done   = started_q && all_known;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      cycles    <= '0;
    end else if (accept) begin
      started_q <= 1'b1;
      cycles    <= '0;
    end else if (step) begin
      cycles    <= cycles + 1'b1;
    end
  end

  // R8
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done && cycles == '0);
  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !req_valid |=> done);
endmodule

// File: rtl/rda_adder.sv
module rda_adder
  import rda_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [W-1:0]  req_a,
  input  logic [W-1:0]  req_b,
  input  logic          req_cin,
  output logic          resp_done,
  output logic [W-1:0]  resp_sum,
  output logic          resp_cout,
  output logic [CW-1:0] resp_cycles
);
  logic [W-1:0] a_q, b_q;
  logic         cin_q;
  rail_t        c0_q;
  rail_t        carry [W+1];
  logic [W:0]   known;
  logic         all_known;
  logic         accept, step;

  rda_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .all_known(all_known),
    .accept(accept), .step(step), .done(resp_done), .cycles(resp_cycles)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      cin_q <= 1'b0;
      c0_q  <= RAIL_EMPTY;
    end else if (accept) begin
      a_q   <= req_a;
      b_q   <= req_b;
      cin_q <= req_cin;
      c0_q  <= RAIL_EMPTY;
    end else if (step && !rail_known(c0_q)) begin
      c0_q  <= rail_from_bit(cin_q);
    end
  end

  assign carry[0] = c0_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    rda_cell u_cell (
      .clk(clk), .rst_n(rst_n), .clear(accept), .step(step),
      .a(a_q[i]), .b(b_q[i]), .cin_pair(carry[i]), .cout_pair(carry[i+1])
    );
    assign resp_sum[i] = a_q[i] ^ b_q[i] ^ rail_value(carry[i]);
  end

  for (genvar j = 0; j <= W; j++) begin : g_known
    assign known[j] = rail_known(carry[j]);
  end

  assign all_known = &known;
  assign resp_cout = rail_value(carry[W]);

  // R7
  cycles_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |-> resp_cycles >= CW'(1) && resp_cycles <= CW'(W + 1));
  // R3
  first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && resp_cycles == '0 && !accept |=> rail_known(carry[0]));
endmodule

// File: tb/rda_adder_test.sv
module rda_adder_test;
  localparam int W = 16;
  localparam int CW = $clog2(W + 2);
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0, req_valid = 0, req_cin = 0;
  logic [W-1:0] req_a = '0, req_b = '0;
  logic resp_done, resp_cout;
  logic [W-1:0] resp_sum;
  logic [CW-1:0] resp_cycles;

  int checks = 0, errors = 0;
  logic [W+CW:0] expq [$];
  int pending = 0;

  always #(TCLK/2) clk = ~clk;

  rda_adder #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_a(req_a), .req_b(req_b),
    .req_cin(req_cin), .resp_done(resp_done), .resp_sum(resp_sum),
    .resp_cout(resp_cout), .resp_cycles(resp_cycles)
  );

  task automatic chk(input string req, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int steps_of(input logic [W-1:0] a, input logic [W-1:0] b);
    int best = 0, run = 0;
    for (int i = 0; i < W; i++) begin
      if (a[i] != b[i]) run++; else run = 0;
      if (run > best) best = run;
    end
    return best + 1;
  endfunction

  task automatic add(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b} + (W+1)'(c);
    expq.push_back({s, CW'(steps_of(a, b))});
    pending++;
    @(negedge clk);
    req_a = a; req_b = b; req_cin = c; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R8 done low after accept", resp_done == 0, resp_done, 0);
    chk("R8 cycles cleared", resp_cycles == 0, resp_cycles, 0);
    while (pending != 0) @(negedge clk);
  endtask

  initial begin : monitor
    logic prev = 0;
    forever begin
      @(negedge clk);
      if (resp_done && !prev) begin
        logic [W+CW:0] e;
        e = expq.pop_front();
        chk("R6 sum/cout", {resp_cout, resp_sum} == e[W+CW:CW], {resp_cout, resp_sum}, e[W+CW:CW]);
        chk("R7 step count", resp_cycles == e[CW-1:0], resp_cycles, e[CW-1:0]);
        pending--;
      end
      prev = resp_done;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk("watchdog", 0, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    logic [W-1:0] keep;
    repeat (3) @(negedge clk);
    chk("R10 reset done", resp_done == 0, resp_done, 0);
    chk("R10 reset cycles", resp_cycles == 0, resp_cycles, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 idle no done", resp_done == 0, resp_done, 0);
    add('0, '0, 0);                      // R3: one step
    chk("R3 zero plus zero one step", resp_cycles == 1, resp_cycles, 1);
    add('0, 16'd1, 0);                   // R7: two steps
    add('1, 16'd1, 0);                   // R7: W steps, R4 ripple
    add('1, '0, 1);                      // R7: W+1 steps
    add(16'hAAAA, 16'h5555, 0);          // R4 full propagate run
    add(16'hF0F0, 16'hF0F0, 1);          // R3 generate only
    // R5 hold across idle cycles
    repeat (5) @(negedge clk);
    chk("R5 done holds", resp_done == 1, resp_done, 1);
    // R9 request during busy ignored
    expq.push_back({17'h10000, CW'(W)});
    pending++;
    req_a = '1; req_b = 16'd1; req_cin = 0; req_valid = 1;
    @(negedge clk);
    req_a = 16'h0003; req_b = 16'h0004; req_valid = 1;
    repeat (3) @(negedge clk);
    req_valid = 0;
    while (pending != 0) @(negedge clk);
    keep = resp_sum;
    chk("R9 busy request ignored", keep == '0 && resp_cout == 1, {resp_cout, keep}, 17'h10000);
    for (int k = 0; k < 40; k++)
      add(W'($urandom), W'($urandom), 1'($urandom));  // R6 R7 random
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule